// File: doc/BRIEF.md
# Instruction Decode and Set-and-Branch Unit

This block sits behind instruction fetch in a small 32-bit processor with sixteen registers. It takes one 16-bit instruction word and splits it into four 4-bit fields: an opcode, then three register selectors called r2, r1 and r0. It reports how many bytes the instruction occupies. It also decides whether the current instruction writes a register, moves the stack pointer, or changes the program counter.

Its main job is the combined set-and-branch instruction. For that instruction, the r2 field is a 4-bit condition. The low three bits select which of three flag bits to test: a constant-one bit, the sign flag and the zero flag. The top bit gives the polarity to compare against. The register named by r1 receives 1 or 0, depending on the outcome. When the condition holds, the 16-bit signed word that follows the instruction is added to the address of the next instruction. Because registers 0 and 1 are read-only, naming one of them as the destination turns the instruction into a pure branch. A zero offset turns it into a pure set.

A halt instruction freezes the unit until reset. Data movement, memory access and arithmetic are handled elsewhere; this unit only grants the write permission and selects the destination.

Top module: `sb_decode`

## Requirements
- R1: `op_code`, `fld_r2`, `fld_r1` and `fld_r0` are bits [15:12], [11:8], [7:4] and [3:0] of `instr`.
- R2: `instr_len` is 6 for opcode 4'hA (load long immediate), 4 for opcode 4'hD (set-and-branch) and 2 for every other opcode.
- R3: For opcode 4'hD, `cond_met` is 1 exactly when ({1, flags[30], flags[29]} & c[2:0]) equals ({3{c[3]}} & c[2:0]), where c is `fld_r2`. Flag position 31 counts as 1 whatever the input holds. For every other opcode `cond_met` is 0.
- R4: For an active set-and-branch instruction, `dst_idx` is the r1 field and `set_val` is `cond_met` zero-extended to 32 bits.
- R5: `dst_we` is never asserted for register index 0 or 1. It is asserted for index 2 to 15 when the instruction writes a destination. Set-and-branch writes to r1. Opcodes 0 (move), 1 (pop), 3 (alu), 4 (move-relative), 7 (load byte), 8 (load long), 9 (load byte immediate), 10 (load long immediate) and 11 (jump-and-link) write to r2. No other opcode writes.
- R6: When the unit is active, `next_pc` is `pc + instr_len`. For a set-and-branch whose condition holds, it is `pc + 4` plus the sign-extended `ext_word`. For halt it is `pc`.
- R7: An active pop (opcode 1) gives `sp_we`=1 and `sp_next`=`sp`+4. An active push (opcode 2) gives `sp_we`=1 and `sp_next`=`sp`-4. Any other opcode gives `sp_we`=0.
- R8: An active halt (opcode 12) sets `halted` at the next clock edge. `halted` stays set until reset. While it is set, `dst_we` and `sp_we` are 0 and `next_pc` equals `pc`.
- R9: With `instr_valid` low, `dst_we` and `sp_we` are 0, `next_pc` equals `pc`, and a halt opcode does not set `halted`.
- R10: After reset, `halted` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| ext_word | input | 16 | Signed branch offset that follows a set-and-branch |
| flags | input | 32 | Flags register (31 one, 30 sign, 29 zero) |
| pc | input | 32 | Address of the current instruction |
| sp | input | 32 | Current stack pointer |
| op_code | output | 4 | Opcode field |
| fld_r2 | output | 4 | First register field, or the condition code |
| fld_r1 | output | 4 | Second register field |
| fld_r0 | output | 4 | Third register field |
| instr_len | output | 3 | Instruction size in bytes |
| cond_met | output | 1 | Set-and-branch condition outcome |
| dst_we | output | 1 | Destination register write permitted |
| dst_idx | output | 4 | Destination register index |
| set_val | output | 32 | Value written by set-and-branch |
| sp_we | output | 1 | Stack pointer update |
| sp_next | output | 32 | New stack pointer |
| next_pc | output | 32 | Address of the next instruction |
| halted | output | 1 | Sticky halt status |

## Verification
The bench targets several condition corners:
- The empty-mask codes, which must always fire.
- A flags input with bit 31 cleared, which must still count as one.
- A mixed-polarity test of sign and zero together.

A polarity or bit-order mistake would invert or misroute these outcomes.

The bench also covers destination and offset corners. Destinations 0 and 1 must lose their write enable while the branch is still taken; a design that forgets this corrupts the constant registers. A negative offset at the most negative value checks that sign extension is applied on top of the 4-byte step, not on top of the bare `pc`.

Halt is checked for stickiness, for silencing the later instructions, and for being ignored while `instr_valid` is low.

// File: rtl/sb_decode.sv
module sb_decode #(
  parameter int XLEN = 32,
  parameter int IW   = 16,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [IW-1:0]   instr,
  input  logic [OFFW-1:0] ext_word,
  input  logic [XLEN-1:0] flags,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] sp,
  output logic [IW/4-1:0] op_code,
  output logic [IW/4-1:0] fld_r2,
  output logic [IW/4-1:0] fld_r1,
  output logic [IW/4-1:0] fld_r0,
  output logic [2:0]      instr_len,
  output logic            cond_met,
  output logic            dst_we,
  output logic [IW/4-1:0] dst_idx,
  output logic [XLEN-1:0] set_val,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_next,
  output logic [XLEN-1:0] next_pc,
  output logic            halted
);
  localparam int FW = IW/4;
  localparam logic [FW-1:0] OP_MOVE = 4'd0,  OP_POP  = 4'd1,  OP_PUSH = 4'd2,
                            OP_ALU  = 4'd3,  OP_MOVR = 4'd4,  OP_LDB  = 4'd7,
                            OP_LDL  = 4'd8,  OP_LDBI = 4'd9,  OP_LDLI = 4'd10,
                            OP_JAL  = 4'd11, OP_HALT = 4'd12, OP_SETB = 4'd13;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic halted_q, active, is_setb, hit, writes_r2;
  logic [2:0] flg;
  logic [XLEN-1:0] seq_pc, off_x;

  assign op_code = instr[IW-1 -: FW];
  assign fld_r2  = instr[3*FW-1 -: FW];
  assign fld_r1  = instr[2*FW-1 -: FW];
  assign fld_r0  = instr[FW-1:0];

  assign active  = instr_valid & ~halted_q;
  assign is_setb = op_code == OP_SETB;
  assign flg     = {1'b1, flags[XLEN-2], flags[XLEN-3]};
  assign hit     = (flg & fld_r2[2:0]) == ({3{fld_r2[3]}} & fld_r2[2:0]);
  assign cond_met = is_setb & hit;

  assign instr_len = (op_code == OP_LDLI) ? 3'd6 : is_setb ? 3'd4 : 3'd2;

  always_comb begin
    case (op_code)
      OP_MOVE, OP_POP, OP_ALU, OP_MOVR, OP_LDB,
      OP_LDL, OP_LDBI, OP_LDLI, OP_JAL: writes_r2 = 1'b1;
      default:                          writes_r2 = 1'b0;
    endcase
  end

  assign dst_idx = is_setb ? fld_r1 : fld_r2;
  assign dst_we  = active & (is_setb | writes_r2) & (dst_idx > FW'(1));
  assign set_val = {{(XLEN-1){1'b0}}, cond_met};

  assign sp_we   = active & ((op_code == OP_POP) | (op_code == OP_PUSH));
  assign sp_next = (op_code == OP_POP)  ? sp + STEP :
                   (op_code == OP_PUSH) ? sp - STEP : sp;

  assign off_x  = {{(XLEN-OFFW){ext_word[OFFW-1]}}, ext_word};
  assign seq_pc = pc + XLEN'(instr_len);
  assign next_pc = (!active || op_code == OP_HALT) ? pc :
                   cond_met ? seq_pc + off_x : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             halted_q <= 1'b0;
    else if (active && op_code == OP_HALT)  halted_q <= 1'b1;
  end
  assign halted = halted_q;

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!dst_we && !sp_we && next_pc == pc));
  p_const_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> dst_idx > FW'(1));
  p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (sp_next == sp + STEP || sp_next == sp - STEP));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!dst_we && !sp_we && next_pc == pc));
  p_halt_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !instr_valid) |=> !halted);
  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_len == 3'd2 || instr_len == 3'd4 || instr_len == 3'd6);
endmodule

// File: tb/sb_decode_tb.sv
module sb_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam logic [31:0] PC0 = 32'h0000_1000;
  localparam logic [31:0] SP0 = 32'h0000_8000;

  localparam logic [15:0] V_INS  [NV] = '{16'hDC50, 16'hD450, 16'hD900, 16'hD970,
    16'hD110, 16'hDA30, 16'hD230, 16'hDBF0, 16'hD020, 16'h0423, 16'hA000, 16'h2600};
  localparam logic [15:0] V_EXT  [NV] = '{16'h0010, 16'h0010, 16'hFFF0, 16'h0010,
    16'h0000, 16'h8000, 16'h0040, 16'h0100, 16'h0002, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [31:0] V_FLG  [NV] = '{32'h0, 32'h0, 32'h2000_0000, 32'h0,
    32'h0, 32'h4000_0000, 32'hC000_0000, 32'h6000_0000, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic        V_COND [NV] = '{1,0,1,0, 1,1,0,1, 1,0,0,0};
  localparam logic        V_WE   [NV] = '{1,1,0,1, 0,1,1,1, 1,1,0,0};
  localparam logic [3:0]  V_IDX  [NV] = '{5,5,0,7, 1,3,3,15, 2,4,0,6};
  localparam logic [2:0]  V_LEN  [NV] = '{4,4,4,4, 4,4,4,4, 4,2,6,2};
  localparam logic [31:0] V_NPC  [NV] = '{32'h1014, 32'h1004, 32'h0FF4, 32'h1004,
    32'h1004, 32'hFFFF_9004, 32'h1004, 32'h1104, 32'h1006, 32'h1002, 32'h1006, 32'h1002};

  logic clk = 0, rst_n = 0, instr_valid = 0;
  logic [15:0] instr = 0, ext_word = 0;
  logic [31:0] flags = 0, pc = PC0, sp = SP0;
  logic [3:0] op_code, fld_r2, fld_r1, fld_r0, dst_idx;
  logic [2:0] instr_len;
  logic cond_met, dst_we, sp_we, halted;
  logic [31:0] set_val, sp_next, next_pc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sb_decode u_dut (.clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ext_word(ext_word), .flags(flags), .pc(pc), .sp(sp), .op_code(op_code),
    .fld_r2(fld_r2), .fld_r1(fld_r1), .fld_r0(fld_r0), .instr_len(instr_len),
    .cond_met(cond_met), .dst_we(dst_we), .dst_idx(dst_idx), .set_val(set_val),
    .sp_we(sp_we), .sp_next(sp_next), .next_pc(next_pc), .halted(halted));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [15:0] w, input logic [15:0] e,
                       input logic [31:0] f);
    @(negedge clk);
    instr_valid = v; instr = w; ext_word = e; flags = f;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 chk("R10 halted after reset", 32'(halted), 0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      apply(1, V_INS[i], V_EXT[i], V_FLG[i]);
      chk($sformatf("R3 cond vec%0d", i), 32'(cond_met), 32'(V_COND[i]));
      chk($sformatf("R5 we vec%0d", i), 32'(dst_we), 32'(V_WE[i]));
      if (V_WE[i]) chk($sformatf("R4 idx vec%0d", i), 32'(dst_idx), 32'(V_IDX[i]));
      if (V_INS[i][15:12] == 4'hD)
        chk($sformatf("R4 val vec%0d", i), set_val, 32'(V_COND[i]));
      chk($sformatf("R2 len vec%0d", i), 32'(instr_len), 32'(V_LEN[i]));
      chk($sformatf("R6 npc vec%0d", i), next_pc, V_NPC[i]);
    end

    apply(1, 16'h5ABC, 0, 0);
    chk("R1 fields", {16'h0, op_code, fld_r2, fld_r1, fld_r0}, 32'h5ABC);
    chk("R5 store no write", 32'(dst_we), 0);

    apply(1, 16'h1500, 0, 0);
    chk("R7 pop we", 32'(sp_we), 1);
    chk("R7 pop sp", sp_next, 32'h8004);
    apply(1, 16'h2500, 0, 0);
    chk("R7 push sp", sp_next, 32'h7FFC);
    apply(1, 16'h3100, 0, 0);
    chk("R7 alu no sp", 32'(sp_we), 0);

    apply(0, 16'hC000, 0, 0);
    chk("R9 idle npc", next_pc, PC0);
    chk("R9 idle we", 32'(dst_we), 0);
    @(posedge clk); #1;
    chk("R9 idle halt ignored", 32'(halted), 0);

    apply(1, 16'hC000, 0, 0);
    chk("R6 halt npc", next_pc, PC0);
    @(posedge clk); #1;
    chk("R8 halted set", 32'(halted), 1);
    apply(1, 16'h0423, 0, 0);
    chk("R8 halted no write", 32'(dst_we), 0);
    chk("R8 halted npc", next_pc, PC0);
    apply(1, 16'h1500, 0, 0);
    chk("R8 halted no sp", 32'(sp_we), 0);
    @(posedge clk); #1;
    chk("R8 halted sticky", 32'(halted), 1);

    @(negedge clk) rst_n = 0;
    #1 chk("R10 reset clears halt", 32'(halted), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule